// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Cycle Controller

This block is the command and data front end of a synchronous, pipelined memory with byte-lane write control. Each word is made of four lanes of nine bits, eight data bits plus a parity bit. Every active clock edge may carry a new command: a load (new address, read or write) or an advance that continues the current burst. The type of the access and the lane mask are registered together with the address. The write data for that access is taken two active edges later, so reads and writes can follow each other on every edge with no idle turnaround.

A small internal array sits behind the pipeline so that the whole path can be checked from the ports. A read that follows a write still in flight returns the write's data, merged lane by lane with the stored word. A clock-enable input freezes the whole pipeline. A sleep input makes the block ignore everything else while it keeps its contents. An output-enable input gates, without waiting for a clock, whether read data is driven. The tri-state bus is modelled as a data output plus a drive flag.

Top module: `sync_pipe_sram`

## Requirements
- R1: A load cycle (load_n = 0) starts an access only when en1_n = 0, en2 = 1 and en3_n = 0. Any other combination starts no access: nothing is written and no read data appears.
- R2: Advance cycles (load_n = 1) that follow a deselecting load, or that come before any load after reset, start no access.
- R3: we_n is sampled only on load cycles (0 = write, 1 = read). On advance cycles it is ignored, and the burst keeps the type it was loaded with.
- R4: The n-th advance after a load at address A accesses the address whose upper bits equal those of A and whose two low bits equal (A[1:0] + n) mod 4.
- R5: Write data is sampled on the second active edge after the command edge. Lane l (wdata bits 9l+8 down to 9l) is stored only if bw_n[l] was 0 on the command edge. bw_n = 0000 writes the full word.
- R6: After the second active edge following a read command, rdata holds the addressed word and the read is valid.
- R7: Commands can be issued on consecutive active edges in any mix. A read always returns the effect of every earlier write, including a write whose data arrives on the same edge that the read accesses the array.
- R8: While cke_n = 1 no pipeline state, stored word or output changes, and wdata is not taken.
- R9: While sleep = 1 all other inputs are ignored, stored words are kept and rdata_drive is 0. Operation resumes when sleep returns to 0.
- R10: rdata_drive is 1 exactly when the output holds valid read data, oe_n = 0 and sleep = 0. A change of oe_n acts at once, without a clock edge.
- R11: During and right after reset, rdata_drive is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| addr | input | ADDR_W | Word address, sampled on load cycles |
| load_n | input | 1 | 0 = load a new address, 1 = advance the burst |
| we_n | input | 1 | Access type on load cycles: 0 write, 1 read |
| en1_n | input | 1 | Active-low chip enable |
| en2 | input | 1 | Active-high chip enable |
| en3_n | input | 1 | Active-low chip enable |
| bw_n | input | LANES | Active-low lane write mask for the command of this cycle |
| cke_n | input | 1 | Active-low clock enable; 1 freezes the pipeline |
| sleep | input | 1 | 1 = ignore all inputs and hold contents |
| oe_n | input | 1 | Active-low output enable, acts without a clock |
| wdata | input | LANES*LANE_W | Write data, taken two active edges after its command |
| rdata | output | LANES*LANE_W | Read data of the latest completed read |
| rdata_drive | output | 1 | Bus drive flag for rdata |

## Verification
The bench aims at the read that directly follows a write to the same word under a partial mask. A controller without forwarding would return the stale word there, and one with a wrong merge would mix the wrong lanes. Bursts start near the end of a four-word group and toggle we_n on advance cycles. A counter that does not wrap would run into the next group, and one that samples we_n again would turn a read burst into writes. Stalls from cke_n and from sleep land between a write command and its data slot. A design that counted frozen edges would store the junk value driven during the stall, and one that ignored sleep on the drive flag would still drive the bus. The seven deselecting enable patterns, each followed by advance cycles, expose any decode that lets a disabled load or its burst reach the array.

// File: rtl/sps_pkg.sv
`timescale 1ns/1ps
package sps_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Device is selected when both active-low enables are low and the active-high one is high.
  function automatic logic chip_selected(input logic en1_n, input logic en2, input logic en3_n);
    return !en1_n && en2 && !en3_n;
  endfunction

endpackage

// File: rtl/sps_cmd_stage.sv
`timescale 1ns/1ps
module sps_cmd_stage
  import sps_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 4,
  parameter int BURST_W    = 2,
  parameter bit INTERLEAVE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              load_n,
  input  logic              we_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_bw_n
);

  localparam int UPPER_W = ADDR_W - BURST_W;

  // Address of burst step n: upper bits fixed, low bits wrap inside the group.
  function automatic logic [ADDR_W-1:0] burst_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [BURST_W-1:0] n);
    logic [BURST_W-1:0] lo;
    if (INTERLEAVE) lo = base[BURST_W-1:0] ^ n;
    else            lo = base[BURST_W-1:0] + n;
    return {base[ADDR_W-1:BURST_W], lo};
  endfunction

  op_e                burst_op_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;

  // Named internal events
  logic               load_cyc;
  logic               sel_now;
  op_e                load_op;
  logic [BURST_W-1:0] cnt_nxt;
  logic [ADDR_W-1:0]  adv_addr;

  assign load_cyc = !load_n;
  assign sel_now  = chip_selected(en1_n, en2, en3_n);
  assign load_op  = !sel_now ? OP_NONE : (we_n ? OP_READ : OP_WRITE);
  assign cnt_nxt  = cnt_q + BURST_W'(1);
  assign adv_addr = burst_addr(base_q, cnt_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_op_q <= OP_NONE;
      base_q     <= '0;
      cnt_q      <= '0;
      s1_op      <= OP_NONE;
      s1_addr    <= '0;
      s1_bw_n    <= '1;
    end else if (act) begin
      s1_bw_n <= bw_n;
      if (load_cyc) begin
        burst_op_q <= load_op;
        base_q     <= addr;
        cnt_q      <= '0;
        s1_op      <= load_op;
        s1_addr    <= addr;
      end else begin
        cnt_q   <= cnt_nxt;
        s1_op   <= burst_op_q;
        s1_addr <= adv_addr;
      end
    end
  end

  // R1: a load without full selection leaves no access in the pipeline
  a_r1_deselect_load: assert property (@(posedge clk) disable iff (!rst_n)
    (act && load_cyc && !sel_now) |=> (s1_op == OP_NONE));

  // R2: advancing a deselected burst stays idle
  a_r2_adv_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !load_cyc && burst_op_q == OP_NONE) |=> (s1_op == OP_NONE));

  // R3: an advance never changes the burst's access type
  a_r3_adv_keeps_type: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !load_cyc) |=> $stable(burst_op_q));

  // R4: advance addresses stay inside the group of the loaded address
  a_r4_adv_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !load_cyc) |=> (s1_addr[ADDR_W-1 -: UPPER_W] == base_q[ADDR_W-1 -: UPPER_W]));

  // R8: frozen edges leave the command stage untouched
  a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> ($stable(s1_op) && $stable(s1_addr) && $stable(s1_bw_n)));

endmodule

// File: rtl/sps_lane_ram.sv
`timescale 1ns/1ps
module sps_lane_ram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lane_n,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && !wr_lane_n[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/sync_pipe_sram.sv
`timescale 1ns/1ps
module sync_pipe_sram
  import sps_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter int BURST_W    = 2,
  parameter bit INTERLEAVE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    load_n,
  input  logic                    we_n,
  input  logic                    en1_n,
  input  logic                    en2,
  input  logic                    en3_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    cke_n,
  input  logic                    sleep,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drive
);

  localparam int DATA_W = LANES * LANE_W;

  // Take each lane from fresh data where its mask bit is low, else keep the old lane.
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [LANES-1:0]  mask_n);
    logic [DATA_W-1:0] res;
    res = old_w;
    for (int l = 0; l < LANES; l++) begin
      if (!mask_n[l]) res[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    end
    return res;
  endfunction

  // Stage 1: command register
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_bw_n;

  // Stage 2: array access done, waiting for data or output slot
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_bw_n;
  logic [DATA_W-1:0] s2_raw;

  // Output register
  logic [DATA_W-1:0] rd_q;
  logic              rd_vld_q;

  // Named internal events
  logic              act;
  logic              exec_wr;
  logic              exec_rd;
  logic              fwd_hit;
  logic [DATA_W-1:0] ram_rd;
  logic [DATA_W-1:0] rd_fwd;

  assign act     = !cke_n && !sleep;
  assign exec_wr = act && (s2_op == OP_WRITE);
  assign exec_rd = act && (s2_op == OP_READ);
  assign fwd_hit = exec_wr && (s1_op == OP_READ) && (s1_addr == s2_addr);
  assign rd_fwd  = fwd_hit ? lane_merge(ram_rd, wdata, s2_bw_n) : ram_rd;

  sps_cmd_stage #(
    .ADDR_W    (ADDR_W),
    .LANES     (LANES),
    .BURST_W   (BURST_W),
    .INTERLEAVE(INTERLEAVE)
  ) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .load_n (load_n),
    .we_n   (we_n),
    .en1_n  (en1_n),
    .en2    (en2),
    .en3_n  (en3_n),
    .addr   (addr),
    .bw_n   (bw_n),
    .s1_op  (s1_op),
    .s1_addr(s1_addr),
    .s1_bw_n(s1_bw_n)
  );

  sps_lane_ram #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_ram (
    .clk      (clk),
    .wr_en    (exec_wr),
    .wr_addr  (s2_addr),
    .wr_lane_n(s2_bw_n),
    .wr_data  (wdata),
    .rd_addr  (s1_addr),
    .rd_data  (ram_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op    <= OP_NONE;
      s2_addr  <= '0;
      s2_bw_n  <= '1;
      s2_raw   <= '0;
      rd_q     <= '0;
      rd_vld_q <= 1'b0;
    end else if (act) begin
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_bw_n  <= s1_bw_n;
      s2_raw   <= rd_fwd;
      rd_vld_q <= (s2_op == OP_READ);
      if (s2_op == OP_READ) rd_q <= s2_raw;
    end
  end

  assign rdata       = rd_q;
  assign rdata_drive = rd_vld_q && !oe_n && !sleep;

  // R6: a read leaving stage 2 makes the output valid on the next edge
  a_r6_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
    exec_rd |=> rd_vld_q);

  // R5: an edge that executes a write or nothing leaves no valid read data
  a_r5_no_read_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (act && s2_op != OP_READ) |=> !rd_vld_q);

  // R7: a forwarded read takes every unmasked lane from the data written on that edge
  a_r7_fwd_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |=> (s2_raw == lane_merge($past(ram_rd), $past(wdata), $past(s2_bw_n))));

  // R8: frozen edges hold the output and its valid flag
  a_r8_out_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> ($stable(rd_q) && $stable(rd_vld_q)));

  // R9: no drive while asleep
  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_drive);

  // R10: drive only with output enable low
  a_r10_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_drive |-> !oe_n);

endmodule

// File: tb/sim_sync_pipe_sram.sv
`timescale 1ns/1ps
module sim_sync_pipe_sram;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        load_n = 1'b0;
  logic        we_n = 1'b1;
  logic        en1_n = 1'b1;
  logic        en2 = 1'b0;
  logic        en3_n = 1'b1;
  logic [3:0]  bw_n = 4'hF;
  logic        cke_n = 1'b0;
  logic        sleep = 1'b0;
  logic        oe_n = 1'b0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rdata_drive;

  always #2.5 clk = ~clk;

  sync_pipe_sram u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .load_n(load_n), .we_n(we_n),
    .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .bw_n(bw_n), .cke_n(cke_n),
    .sleep(sleep), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_tag = "R11";

  // Reference state built from the requirements
  logic [35:0] model [64];
  int          m1_op = 0, m2_op = 0, b_op = 0;   // 0 none, 1 read, 2 write
  logic [5:0]  m1_a = '0, m2_a = '0, b_base = '0;
  logic [3:0]  m1_bw = 4'hF, m2_bw = 4'hF;
  logic [35:0] m1_d = '0, m2_d = '0;
  logic [1:0]  b_cnt = '0;
  logic        e_vld = 1'b0;
  logic [35:0] e_data = '0;
  int          seq = 1;

  function automatic logic [35:0] pattern(input int n);
    logic [35:0] x;
    x = 36'(n) * 36'h53A7C9E1B + 36'h2468ACE13;
    return x ^ {x[17:0], x[35:18]};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [35:0] got, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", cur_tag, what, got, exp);
    end
  endtask

  // One clock slot: drive a command, update the reference, check after the edge.
  task automatic step(input logic ld_n, input logic wen, input logic [2:0] cs, input logic [5:0] a,
                      input logic [3:0] bw, input logic ck_n, input logic slp, input logic oen);
    bit          active;
    int          op;
    logic [1:0]  lo;
    active = !ck_n && !slp;
    load_n = ld_n; we_n = wen; {en1_n, en2, en3_n} = cs; addr = a; bw_n = bw;
    cke_n = ck_n; sleep = slp; oe_n = oen;
    wdata = (active && m2_op == 2) ? m2_d : (36'hF0F0F0F0F ^ pattern(seq + 5000));
    if (active) begin
      if (m2_op == 2) begin
        for (int l = 0; l < 4; l++)
          if (!m2_bw[l]) model[m2_a][l*9 +: 9] = m2_d[l*9 +: 9];
      end
      e_vld = (m2_op == 1);
      if (m2_op == 1) e_data = model[m2_a];
      m2_op = m1_op; m2_a = m1_a; m2_bw = m1_bw; m2_d = m1_d;
      if (!ld_n) begin
        op = (cs == 3'b010) ? (wen ? 1 : 2) : 0;
        b_op = op; b_base = a; b_cnt = 2'd0; m1_a = a;
      end else begin
        b_cnt = b_cnt + 2'd1;
        lo = b_base[1:0] + b_cnt;
        m1_a = {b_base[5:2], lo};
        op = b_op;
      end
      m1_op = op; m1_bw = bw; m1_d = pattern(seq); seq++;
    end
    @(posedge clk); #1;
    chk(rdata_drive === (e_vld && !oen && !slp), "drive", {35'd0, rdata_drive},
        {35'd0, e_vld && !oen && !slp});
    if (e_vld) chk(rdata === e_data, "rdata", rdata, e_data);
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] bw); step(0, 0, 3'b010, a, bw, 0, 0, 0); endtask
  task automatic rd(input logic [5:0] a); step(0, 1, 3'b010, a, 4'hF, 0, 0, 0); endtask
  task automatic adv(input logic wen, input logic [3:0] bw); step(1, wen, 3'b010, 6'd0, bw, 0, 0, 0); endtask
  task automatic idle(); step(0, 1, 3'b110, 6'd0, 4'hF, 0, 0, 0); endtask
  task automatic flush(); idle(); idle(); idle(); endtask

  initial begin
    #750000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(rdata_drive === 1'b0, "drive in reset", {35'd0, rdata_drive}, 36'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(rdata_drive === 1'b0, "drive after reset", {35'd0, rdata_drive}, 36'd0);

    // R2: advance before any load
    cur_tag = "R2";
    adv(1, 4'hF); adv(0, 4'h0); adv(1, 4'hF);
    flush();

    // R5 full-width fill, R6 read back
    cur_tag = "R5";
    for (int a = 0; a < 64; a++) wr(6'(a), 4'h0);
    flush();
    cur_tag = "R6";
    for (int a = 0; a < 64; a++) rd(6'(a));
    flush();

    // R5: every lane mask pattern
    cur_tag = "R5";
    for (int a = 0; a < 16; a++) wr(6'(a), 4'(a));
    for (int a = 0; a < 16; a++) rd(6'(a));
    flush();

    // R7: read directly behind a masked write to the same word, and mixed pairs
    cur_tag = "R7";
    for (int k = 0; k < 16; k++) begin
      wr(6'(20 + k), 4'(k * 7));
      rd(6'(20 + k));
    end
    for (int k = 0; k < 8; k++) begin
      wr(6'(36 + k), 4'(k));
      rd(6'(36 + k));
      rd(6'(20 + k));
      wr(6'(36 + k), 4'(15 - k));
      rd(6'(36 + k));
    end
    flush();

    // R3 / R4: write burst with we_n high on advances, read burst with we_n low
    cur_tag = "R3";
    wr(6'd34, 4'h0); adv(1, 4'h0); adv(1, 4'h3); adv(1, 4'h0);
    rd(6'd33); adv(0, 4'h0); adv(0, 4'h0); adv(0, 4'h0);
    flush();
    cur_tag = "R4";
    rd(6'd34); adv(1, 4'hF); adv(1, 4'hF); adv(1, 4'hF);
    rd(6'd35); adv(0, 4'hF);
    flush();

    // R1 / R2: every deselecting enable pattern, with advances behind it
    cur_tag = "R1";
    for (int c = 0; c < 8; c++) begin
      if (c != 2) begin
        step(0, 0, 3'(c), 6'd44, 4'h0, 0, 0, 0);
        step(1, 0, 3'(c), 6'd0, 4'h0, 0, 0, 0);
        step(1, 0, 3'(c), 6'd0, 4'h0, 0, 0, 0);
      end
    end
    flush();
    cur_tag = "R2";
    rd(6'd44); rd(6'd45); rd(6'd46);
    flush();

    // R8: clock-enable stalls between a write and its data slot, and on a read
    cur_tag = "R8";
    wr(6'd50, 4'h0);
    step(0, 0, 3'b010, 6'd51, 4'h0, 1, 0, 0);
    idle();
    step(0, 0, 3'b010, 6'd52, 4'h0, 1, 0, 0);
    step(0, 0, 3'b010, 6'd53, 4'h0, 1, 0, 0);
    idle();
    rd(6'd50);
    step(0, 1, 3'b010, 6'd51, 4'hF, 1, 0, 0);
    idle(); idle();
    step(0, 1, 3'b010, 6'd52, 4'hF, 1, 0, 0);
    step(0, 1, 3'b010, 6'd52, 4'hF, 1, 0, 0);
    rd(6'd51); rd(6'd52);
    flush();

    // R9: sleep between write and data, and while read data is valid
    cur_tag = "R9";
    wr(6'd54, 4'h0);
    step(0, 0, 3'b010, 6'd55, 4'h0, 0, 1, 0);
    idle();
    step(0, 0, 3'b010, 6'd56, 4'h0, 0, 1, 0);
    idle();
    rd(6'd54); idle(); idle();
    step(0, 0, 3'b010, 6'd54, 4'h0, 0, 1, 0);
    step(0, 0, 3'b010, 6'd54, 4'h0, 0, 1, 0);
    idle();
    rd(6'd55); rd(6'd56); rd(6'd54);
    flush();

    // R10: output enable acts between edges
    cur_tag = "R10";
    rd(6'd7); idle(); idle();
    oe_n = 1'b1; #1;
    chk(rdata_drive === 1'b0, "oe high", {35'd0, rdata_drive}, 36'd0);
    oe_n = 1'b0; #1;
    chk(rdata_drive === 1'b1, "oe low", {35'd0, rdata_drive}, 36'd1);
    step(0, 1, 3'b110, 6'd0, 4'hF, 0, 0, 1);
    flush();

    // R7: mixed stream over a small window with stalls
    cur_tag = "R7";
    for (int i = 0; i < 400; i++) begin
      logic [35:0] h;
      h = pattern(i + 9000);
      step(h[0] & h[1], h[2], (h[3:5] == 3'b000) ? 3'b110 : 3'b010, {3'b000, h[8:6]}, h[12:9],
           h[13] & h[14] & h[15], h[16] & h[17] & h[18] & h[19], 1'b0);
    end
    flush();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule